// File: doc/BRIEF.md
# ATA Task-File Register Interface

This block is the device side of a disk's command register file as a host sees it through a small I/O port. The host reaches eight offsets with a single-cycle strobe. Offsets 1 to 6 hold the command parameters: feature, sector count, three address bytes and the device/head byte. Offset 7 takes a command on a write and returns status on a read. Offset 1 returns the error byte on a read. Offset 0 is the data port of the programmed-I/O read phase.

Two commands are carried out. The identify command opens a read phase of a fixed number of words, 256 by default. The words come from a backend that returns the word for the index the block presents. The flush command holds the block busy until the backend reports completion, either with or without failure. Any other opcode is rejected at once. The block raises an interrupt request on each completion, and a status read drops it.

Top module: `ata_taskfile`

## Requirements
- R1: After reset, status (offset 7) reads 0x40, meaning DRDY (bit 6) only; the error byte (offset 1) reads 0x00; irq_o is low.
- R2: Host writes to offsets 1 (feature), 2 (sector count), 3, 4 and 5 (address bytes) and 6 (device) are stored. Offsets 2 to 6 read back the written byte in bits 7:0 with the upper bits zero. A read of offset 1 returns the error byte, never the feature.
- R3: tf_lba presents {device[3:0], offset 5, offset 4, offset 3}. dev1_sel follows device bit 4 and lba_mode follows device bit 6.
- R4: Writing opcode 0xEC to offset 7 while idle starts a read phase. Before each of the ID_WORDS data reads, status reads 0x48 (DRDY and DRQ, bit 3). Data read k returns the backend word for index k.
- R5: The read that takes the last word ends the phase and status returns to 0x40. Data reads outside a phase return 0 and change nothing.
- R6: Writing opcode 0xE7 while idle makes status read 0xC0 (BSY, bit 7, with DRDY) and raises flush_req until be_done. After be_done without be_fail, status reads 0x40.
- R7: A flush completed with be_fail set leaves status at 0x41 (ERR, bit 0) and the error byte at 0x04 (abort).
- R8: Any opcode other than 0xEC or 0xE7 completes in the next cycle with status 0x41 and error byte 0x04.
- R9: A write to offset 7 while BSY or DRQ is set is ignored: the status, the data word sequence and flush_req are unchanged.
- R10: irq_o rises in the cycle after each completion: the start of the identify phase, the end of a flush, or a rejected opcode. A status read lowers it in the following cycle unless a completion lands in the same cycle, in which case irq_o stays high. Error-byte reads leave irq_o unchanged.
- R11: Each accepted command clears ERR and the error byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_stb | input | 1 | Host access strobe, one cycle per access |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_addr | input | 3 | Register offset |
| hst_wdata | input | DATA_W | Write data; byte registers use bits 7:0 |
| hst_rdata | output | DATA_W | Read data for the offset currently addressed |
| irq_o | output | 1 | Interrupt request |
| id_index | output | $clog2(ID_WORDS) | Index of the identify word requested |
| id_word | input | DATA_W | Backend word for id_index |
| flush_req | output | 1 | Flush pending at the backend |
| be_done | input | 1 | Backend completes the pending flush |
| be_fail | input | 1 | Qualifies be_done as failed |
| tf_lba | output | 28 | Assembled block address |
| tf_count | output | 8 | Sector count register |
| tf_feature | output | 8 | Feature register |
| dev1_sel | output | 1 | Device 1 selected |
| lba_mode | output | 1 | Block addressing selected |

## Verification
On every cycle, the assertions check that the sequencer holds its busy and data-phase states until be_done or a data read moves them. They also check that the last data read returns the block to idle, that rejected and failed commands post the abort code, and that the interrupt latch follows its set and clear events with set taking priority. Only the bench scenarios can show the full status values seen at the port, the word order of the data phase, the register readback and address assembly, and the fact that a command written during a busy or data phase leaves the following status and data reads unchanged.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_PIO  = 2'd1,
      SQ_BUSY = 2'd2
   } sq_state_t;

   localparam logic [2:0] OFS_DATA    = 3'd0;
   localparam logic [2:0] OFS_ERRFEAT = 3'd1;
   localparam logic [2:0] OFS_COUNT   = 3'd2;
   localparam logic [2:0] OFS_ADDR0   = 3'd3;
   localparam logic [2:0] OFS_ADDR1   = 3'd4;
   localparam logic [2:0] OFS_ADDR2   = 3'd5;
   localparam logic [2:0] OFS_DEVICE  = 3'd6;
   localparam logic [2:0] OFS_CMDSTAT = 3'd7;

   localparam logic [7:0] OP_IDENTIFY = 8'hEC;
   localparam logic [7:0] OP_FLUSH    = 8'hE7;
   localparam logic [7:0] ERR_ABORT   = 8'h04;

   localparam int ST_BSY  = 7;
   localparam int ST_DRDY = 6;
   localparam int ST_DF   = 5;
   localparam int ST_DRQ  = 3;
   localparam int ST_ERR  = 0;

   localparam int DEV_SEL_BIT = 4;
   localparam int DEV_LBA_BIT = 6;

endpackage

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
   import ata_tf_pkg::*;
#(
   parameter int FIRST_OFS = 1,
   parameter int LAST_OFS  = 6
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [2:0]                      addr,
   input  logic [7:0]                      wdata,
   output logic [LAST_OFS:FIRST_OFS][7:0]  bytes_o
);

   initial begin : p_param_chk
      assert (FIRST_OFS >= 1 && LAST_OFS <= 6 && FIRST_OFS <= LAST_OFS)
         else $error("ata_tf_regs: offset range must lie within 1..6");
   end

   // One byte register per offset; the decode compares against the offset.
   generate
      for (genvar g = FIRST_OFS; g <= LAST_OFS; g++) begin : g_byte
         logic [7:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (wr_en && addr == 3'(g))
               q <= wdata;
         end
         assign bytes_o[g] = q;
      end
   endgenerate

endmodule

// File: rtl/ata_tf_irq.sv
module ata_tf_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic clr_evt,
   output logic irq_o
);

   logic pend_q;

   // A completion in the same cycle as a status read wins.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= 1'b0;
      else if (set_evt)
         pend_q <= 1'b1;
      else if (clr_evt)
         pend_q <= 1'b0;
   end

   assign irq_o = pend_q;

   assert_irq_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt |=> irq_o);

   assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_evt && !set_evt) |=> !irq_o);

   assert_irq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_evt && !set_evt) |=> $stable(irq_o));

endmodule

// File: rtl/ata_tf_seq.sv
module ata_tf_seq
   import ata_tf_pkg::*;
#(
   parameter int ID_WORDS = 256,
   localparam int IDX_W   = $clog2(ID_WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  logic [7:0]       cmd_op,
   input  logic             data_rd,
   input  logic             be_done,
   input  logic             be_fail,
   output logic [7:0]       status_o,
   output logic [7:0]       err_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             flush_req_o,
   output logic             drq_o,
   output logic             set_evt_o
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ID_WORDS - 1);

   initial begin : p_param_chk
      assert (ID_WORDS >= 2) else $error("ata_tf_seq: ID_WORDS must be at least 2");
   end

   sq_state_t        state;
   logic [IDX_W-1:0] idx;
   logic             err_q;
   logic [7:0]       err_reg;
   logic             accept;
   logic             known_op;

   assign accept   = cmd_wr && (state == SQ_IDLE);
   assign known_op = (cmd_op == OP_IDENTIFY) || (cmd_op == OP_FLUSH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SQ_IDLE;
         idx     <= '0;
         err_q   <= 1'b0;
         err_reg <= '0;
      end else begin
         unique case (state)
            SQ_IDLE: begin
               if (cmd_wr) begin
                  err_q   <= 1'b0;
                  err_reg <= '0;
                  if (cmd_op == OP_IDENTIFY) begin
                     state <= SQ_PIO;
                     idx   <= '0;
                  end else if (cmd_op == OP_FLUSH) begin
                     state <= SQ_BUSY;
                  end else begin
                     err_q   <= 1'b1;
                     err_reg <= ERR_ABORT;
                  end
               end
            end
            SQ_PIO: begin
               if (data_rd) begin
                  if (idx == LAST_IDX) begin
                     state <= SQ_IDLE;
                     idx   <= '0;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
            SQ_BUSY: begin
               if (be_done) begin
                  state <= SQ_IDLE;
                  if (be_fail) begin
                     err_q   <= 1'b1;
                     err_reg <= ERR_ABORT;
                  end
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   always_comb begin
      status_o          = '0;
      status_o[ST_BSY]  = (state == SQ_BUSY);
      status_o[ST_DRDY] = 1'b1;
      status_o[ST_DF]   = 1'b0;
      status_o[ST_DRQ]  = (state == SQ_PIO);
      status_o[ST_ERR]  = err_q;
   end

   assign err_o       = err_reg;
   assign idx_o       = idx;
   assign drq_o       = (state == SQ_PIO);
   assign flush_req_o = (state == SQ_BUSY);
   assign set_evt_o   = (accept && cmd_op != OP_FLUSH) ||
                        ((state == SQ_BUSY) && be_done);

   assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_BUSY && !be_done) |=> (state == SQ_BUSY));

   assert_pio_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_PIO && !data_rd) |=> (state == SQ_PIO && $stable(idx)));

   assert_pio_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_PIO && data_rd && idx == LAST_IDX) |=> (state == SQ_IDLE));

   assert_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !known_op) |=> (err_q && err_reg == ERR_ABORT && state == SQ_IDLE));

   assert_flush_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_BUSY && be_done && be_fail) |=> (err_q && err_reg == ERR_ABORT));

   assert_accept_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && known_op) |=> (!err_q && err_reg == 8'h00));

endmodule

// File: rtl/ata_taskfile.sv
module ata_taskfile
   import ata_tf_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int ID_WORDS = 256
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        hst_stb,
   input  logic                        hst_wr,
   input  logic [2:0]                  hst_addr,
   input  logic [DATA_W-1:0]           hst_wdata,
   output logic [DATA_W-1:0]           hst_rdata,
   output logic                        irq_o,
   output logic [$clog2(ID_WORDS)-1:0] id_index,
   input  logic [DATA_W-1:0]           id_word,
   output logic                        flush_req,
   input  logic                        be_done,
   input  logic                        be_fail,
   output logic [27:0]                 tf_lba,
   output logic [7:0]                  tf_count,
   output logic [7:0]                  tf_feature,
   output logic                        dev1_sel,
   output logic                        lba_mode
);

   localparam int FIRST_REG = 1;
   localparam int LAST_REG  = 6;
   localparam int IDX_W     = $clog2(ID_WORDS);

   initial begin : p_param_chk
      assert (DATA_W >= 8) else $error("ata_taskfile: DATA_W must be at least 8");
   end

   logic                              host_wr;
   logic                              host_rd;
   logic                              reg_wr;
   logic                              cmd_wr;
   logic                              data_rd;
   logic                              stat_rd;
   logic [LAST_REG:FIRST_REG][7:0]    tf_bytes;
   logic [7:0]                        status;
   logic [7:0]                        err_byte;
   logic                              drq;
   logic                              set_evt;
   logic [7:0]                        rd_byte;
   logic [DATA_W-1:0]                 data_word;
   logic [IDX_W-1:0]                  idx;

   assign host_wr = hst_stb && hst_wr;
   assign host_rd = hst_stb && !hst_wr;
   assign reg_wr  = host_wr && (hst_addr != OFS_DATA) && (hst_addr != OFS_CMDSTAT);
   assign cmd_wr  = host_wr && (hst_addr == OFS_CMDSTAT);
   assign data_rd = host_rd && (hst_addr == OFS_DATA);
   assign stat_rd = host_rd && (hst_addr == OFS_CMDSTAT);

   ata_tf_regs #(
      .FIRST_OFS (FIRST_REG),
      .LAST_OFS  (LAST_REG)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr),
      .addr    (hst_addr),
      .wdata   (hst_wdata[7:0]),
      .bytes_o (tf_bytes)
   );

   ata_tf_seq #(
      .ID_WORDS (ID_WORDS)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_wr      (cmd_wr),
      .cmd_op      (hst_wdata[7:0]),
      .data_rd     (data_rd),
      .be_done     (be_done),
      .be_fail     (be_fail),
      .status_o    (status),
      .err_o       (err_byte),
      .idx_o       (idx),
      .flush_req_o (flush_req),
      .drq_o       (drq),
      .set_evt_o   (set_evt)
   );

   ata_tf_irq u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (set_evt),
      .clr_evt (stat_rd),
      .irq_o   (irq_o)
   );

   always_comb begin
      unique case (hst_addr)
         OFS_ERRFEAT: rd_byte = err_byte;
         OFS_COUNT:   rd_byte = tf_bytes[2];
         OFS_ADDR0:   rd_byte = tf_bytes[3];
         OFS_ADDR1:   rd_byte = tf_bytes[4];
         OFS_ADDR2:   rd_byte = tf_bytes[5];
         OFS_DEVICE:  rd_byte = tf_bytes[6];
         OFS_CMDSTAT: rd_byte = status;
         default:     rd_byte = '0;
      endcase
   end

   assign data_word = drq ? id_word : '0;

   generate
      if (DATA_W == 8) begin : g_narrow
         assign hst_rdata = (hst_addr == OFS_DATA) ? data_word : rd_byte;
      end else begin : g_wide
         logic unused_wdata_hi;
         assign unused_wdata_hi = ^hst_wdata[DATA_W-1:8];
         assign hst_rdata = (hst_addr == OFS_DATA) ? data_word
                                                   : {{(DATA_W-8){1'b0}}, rd_byte};
      end
   endgenerate

   assign id_index   = idx;
   assign tf_feature = tf_bytes[1];
   assign tf_count   = tf_bytes[2];
   assign tf_lba     = {tf_bytes[6][3:0], tf_bytes[5], tf_bytes[4], tf_bytes[3]};
   assign dev1_sel   = tf_bytes[6][DEV_SEL_BIT];
   assign lba_mode   = tf_bytes[6][DEV_LBA_BIT];

endmodule

// File: tb/ata_taskfile_tb.sv
module ata_taskfile_tb;

   localparam int CLK_NS = 20;
   localparam int NWORDS = 256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stb = 1'b0;
   logic        wr = 1'b0;
   logic [2:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        irq;
   logic [7:0]  id_index;
   logic [15:0] id_word;
   logic        flush_req;
   logic        be_done = 1'b0;
   logic        be_fail = 1'b0;
   logic [27:0] tf_lba;
   logic [7:0]  tf_count;
   logic [7:0]  tf_feature;
   logic        dev1_sel;
   logic        lba_mode;

   int n_chk = 0;
   int n_err = 0;
   bit done_flag = 0;

   // Reference model state
   int         m_state = 0;   // 0 idle, 1 data phase, 2 busy
   int         m_idx = 0;
   bit         m_err = 0;
   logic [7:0] m_errreg = 8'h00;
   bit         m_irq = 0;
   logic [7:0] m_tf [0:7];

   always #(CLK_NS/2) clk = ~clk;

   function automatic logic [15:0] idw(int k);
      return 16'hA500 ^ 16'(k * 16'h0103);
   endfunction

   assign id_word = idw(int'(id_index));

   ata_taskfile #(.DATA_W(16), .ID_WORDS(NWORDS)) u_dut (
      .clk(clk), .rst_n(rst_n), .hst_stb(stb), .hst_wr(wr), .hst_addr(addr),
      .hst_wdata(wdata), .hst_rdata(rdata), .irq_o(irq), .id_index(id_index),
      .id_word(id_word), .flush_req(flush_req), .be_done(be_done), .be_fail(be_fail),
      .tf_lba(tf_lba), .tf_count(tf_count), .tf_feature(tf_feature),
      .dev1_sel(dev1_sel), .lba_mode(lba_mode)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] m_status();
      logic [7:0] s = 8'h40;
      if (m_state == 2) s[7] = 1'b1;
      if (m_state == 1) s[3] = 1'b1;
      s[0] = m_err;
      return s;
   endfunction

   function automatic logic [15:0] exp_rd(logic [2:0] a);
      case (a)
         3'd0:    return (m_state == 1) ? idw(m_idx) : 16'h0000;
         3'd1:    return {8'h00, m_errreg};
         3'd7:    return {8'h00, m_status()};
         default: return {8'h00, m_tf[a]};
      endcase
   endfunction

   task automatic model_step(bit s, bit w, logic [2:0] a, logic [15:0] d, bit dn, bit fl);
      bit set_e = 0;
      bit clr_e = 0;
      int st_old = m_state;
      if (s && w) begin
         if (a >= 3'd1 && a <= 3'd6) m_tf[a] = d[7:0];
         else if (a == 3'd7 && st_old == 0) begin
            m_err = 0; m_errreg = 8'h00;
            if (d[7:0] == 8'hEC) begin m_state = 1; m_idx = 0; set_e = 1; end
            else if (d[7:0] == 8'hE7) m_state = 2;
            else begin m_err = 1; m_errreg = 8'h04; set_e = 1; end
         end
      end
      if (s && !w) begin
         if (a == 3'd0 && st_old == 1) begin
            m_idx++;
            if (m_idx == NWORDS) begin m_state = 0; m_idx = 0; end
         end
         if (a == 3'd7) clr_e = 1;
      end
      if (dn && st_old == 2) begin
         m_state = 0;
         if (fl) begin m_err = 1; m_errreg = 8'h04; end
         set_e = 1;
      end
      if (set_e) m_irq = 1;
      else if (clr_e) m_irq = 0;
   endtask

   task automatic acc(bit s, bit w, logic [2:0] a, logic [15:0] d, bit dn, bit fl, string tag);
      @(negedge clk);
      stb = s; wr = w; addr = a; wdata = d; be_done = dn; be_fail = fl;
      #(CLK_NS/4);
      if (s && !w) check(tag, 32'(rdata), 32'(exp_rd(a)));
      @(posedge clk);
      model_step(s, w, a, d, dn, fl);
   endtask

   task automatic wr_reg(logic [2:0] a, logic [7:0] d, string tag);
      acc(1, 1, a, {8'h00, d}, 0, 0, tag);
   endtask

   task automatic rd_reg(logic [2:0] a, string tag);
      acc(1, 0, a, 16'h0000, 0, 0, tag);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) acc(0, 0, 3'd0, 16'h0000, 0, 0, "idle");
   endtask

   task automatic port_checks();
      #(CLK_NS/4);
      check("R3 lba", 32'(tf_lba), 32'({m_tf[6][3:0], m_tf[5], m_tf[4], m_tf[3]}));
      check("R2 count", 32'(tf_count), 32'(m_tf[2]));
      check("R2 feature", 32'(tf_feature), 32'(m_tf[1]));
      check("R3 dev1", 32'(dev1_sel), 32'(m_tf[6][4]));
      check("R3 lba mode", 32'(lba_mode), 32'(m_tf[6][6]));
   endtask

   // Every-clock comparison of the registered outputs with the model
   always @(negedge clk) begin
      if (rst_n && !done_flag) begin
         check("R10 irq", 32'(irq), 32'(m_irq));
         check("R6 flush_req", 32'(flush_req), 32'(m_state == 2));
      end
   end

   task automatic finish_run();
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin : watchdog
      #(CLK_NS * 200000);
      n_err++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin : stim
      for (int i = 0; i < 8; i++) m_tf[i] = 8'h00;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      rd_reg(3'd7, "R1 status");
      rd_reg(3'd1, "R1 error");
      check("R1 irq", 32'(irq), 32'd0);

      // R2 / R3 register file
      wr_reg(3'd1, 8'h5A, "R2");
      wr_reg(3'd2, 8'h11, "R2");
      wr_reg(3'd3, 8'h33, "R2");
      wr_reg(3'd4, 8'h44, "R2");
      wr_reg(3'd5, 8'h55, "R2");
      wr_reg(3'd6, 8'h5C, "R3");
      for (int a = 1; a <= 6; a++) rd_reg(3'(a), "R2 readback");
      port_checks();
      wr_reg(3'd6, 8'h0A, "R3");
      port_checks();

      // R4 / R5 identify phase, with a command during the phase (R9)
      wr_reg(3'd7, 8'hEC, "R4");
      for (int k = 0; k < NWORDS; k++) begin
         rd_reg(3'd7, "R4 status");
         rd_reg(3'd0, "R4 data");
         if (k == 10) begin
            wr_reg(3'd7, 8'hE7, "R9");
            wr_reg(3'd7, 8'h22, "R9");
         end
      end
      rd_reg(3'd7, "R5 status");
      rd_reg(3'd0, "R5 data");
      rd_reg(3'd7, "R5 status");

      // R6 flush, command while busy (R9)
      wr_reg(3'd7, 8'hE7, "R6");
      idle(3);
      rd_reg(3'd7, "R6 status");
      wr_reg(3'd7, 8'hEC, "R9");
      rd_reg(3'd7, "R9 status");
      rd_reg(3'd0, "R9 data");
      acc(0, 0, 3'd0, 16'h0000, 1, 0, "R6 done");
      rd_reg(3'd1, "R10 error read");
      rd_reg(3'd7, "R6 status");

      // R7 failed flush, R11 clearing
      wr_reg(3'd7, 8'hE7, "R7");
      idle(2);
      acc(0, 0, 3'd0, 16'h0000, 1, 1, "R7 done");
      rd_reg(3'd7, "R7 status");
      rd_reg(3'd1, "R7 error");
      wr_reg(3'd7, 8'hE7, "R11");
      rd_reg(3'd7, "R11 status");
      rd_reg(3'd1, "R11 error");
      // R10: completion coincides with a status read
      acc(1, 0, 3'd7, 16'h0000, 1, 0, "R10 coincide");
      idle(1);
      rd_reg(3'd1, "R10 error read");
      rd_reg(3'd7, "R10 clear");

      // R8 rejected opcodes
      wr_reg(3'd7, 8'h55, "R8");
      rd_reg(3'd7, "R8 status");
      rd_reg(3'd1, "R8 error");
      wr_reg(3'd7, 8'h00, "R8");
      rd_reg(3'd7, "R8 status");
      wr_reg(3'd7, 8'hEC, "R11");
      rd_reg(3'd1, "R11 error");
      rd_reg(3'd7, "R11 status");
      idle(2);

      finish_run();
   end

endmodule